// File: doc/BRIEF.md
# Packed Vector Register Move Unit

This block holds eight 128-bit vector registers, each made of four 32-bit lanes, and carries out data-movement operations on them. An operation arrives as a 4-bit code, a destination index, a source index and a byte address. The unit can load a register from memory, store a register to memory, or copy between registers. It can also replace one quadword half of a register, move the lowest lane, or fold the four lane sign bits into a small scalar mask. It does no arithmetic and decodes no machine code.

Memory is reached through a synchronous port 128 bits wide. The port takes a byte address and 16 byte strobes, and read data comes back one cycle after the request. One operation is in flight at a time. `op_ready` is high in the idle state, and `done` pulses for one cycle when an operation finishes. The two aligned full-width transfer codes check that the address is a multiple of 16. If it is not, the operation raises `fault` and touches nothing.

The controller has three states. `ST_IDLE` accepts an operation when `op_valid` is high and moves to `ST_EXEC`. In `ST_EXEC`, a register-only operation, a store, a faulting operation or the no-op finishes and returns to `ST_IDLE`. A load instead issues its memory request and moves to `ST_LOAD`. In `ST_LOAD` the returned data is merged into the destination register, and the controller returns to `ST_IDLE`.

Top module: `vmov_unit`

## Requirements
- R1: Code 0 loads all 128 bits from memory into register dst. Code 1 stores all of register src with strobes 16'hFFFF. Code 4 copies register src into register dst. Memory byte address+k maps to vector bits [8k+7:8k].
- R2: Codes 0 and 1 with address bits [3:0] not zero raise `fault` and make no memory request and no register or mask write. `fault` stays high until the next operation is accepted, and it is low after that acceptance.
- R3: Codes 2 (load) and 3 (store) act like codes 0 and 1 at any address and never raise `fault`.
- R4: Code 5 loads 32 bits into lane 0 (bits [31:0]) and zeroes lanes 1–3. Code 6 stores lane 0 of src with strobes 16'h000F. Code 7 copies lane 0 of src into lane 0 of dst and keeps lanes 1–3 of dst.
- R5: Code 8 loads 64 bits into bits [63:0] of dst and keeps bits [127:64]. Code 9 stores bits [63:0] of src with strobes 16'h00FF.
- R6: Code 10 loads 64 bits into bits [127:64] of dst and keeps bits [63:0]. Code 11 stores bits [127:64] of src to address..address+7 with strobes 16'h00FF.
- R7: Code 12 writes bits [63:0] of src into bits [127:64] of dst and keeps dst bits [63:0].
- R8: Code 13 writes bits [127:64] of src into bits [63:0] of dst and keeps dst bits [127:64].
- R9: Code 14 sets `mask_out` to the sign bits of src (bit 31 + 32·i of the vector goes to mask bit i) and zeroes bits [31:4]. `mask_out` holds until the next code 14.
- R10: `done` is a one-cycle pulse. It comes 2 clock edges after acceptance for non-loads and faulting operations, and 3 edges after acceptance for loads. `mem_req` lasts exactly one cycle. Code 15 completes in 2 edges with no effect.
- R11: An operation accepted in the cycle where `done` is high reads the register value written by the operation just completed.
- R12: After reset `op_ready` is 1, `done`, `fault` and `mem_req` are 0, `mask_out` is 0, and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | Operation code |
| op_dst | input | 3 | Destination register index |
| op_src | input | 3 | Source register index |
| op_addr | input | 32 | Byte address for memory operations |
| op_ready | output | 1 | Unit idle, operation accepted this cycle if valid |
| done | output | 1 | Operation completion pulse |
| fault | output | 1 | Alignment fault, held until next acceptance |
| mask_out | output | 32 | Zero-extended lane sign mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 128 | Write data |
| mem_wstrb | output | 16 | Byte write strobes |
| mem_rdata | input | 128 | Read data, valid one cycle after a read request |

## Verification
The two things that can share one cycle are the completion of an operation, with its `done` pulse, and the acceptance of the next one. This carries the register write-back together with the read of that register by the follower, and also the clearing of a held `fault` together with a new issue. The bench meets this on every operation: each operation in the sweep over codes, addresses and register pairs is followed at once by a full store of its destination register, issued in the cycle where `done` is high. The stored bytes are compared against a shadow model of registers and memory built from the requirements. Faulting operations are also followed at once by new work, and the bench checks that `fault` falls right after that acceptance.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

    typedef enum logic [3:0] {
        OP_ALD  = 4'd0,
        OP_AST  = 4'd1,
        OP_ULD  = 4'd2,
        OP_UST  = 4'd3,
        OP_VMOV = 4'd4,
        OP_SLD  = 4'd5,
        OP_SST  = 4'd6,
        OP_SMOV = 4'd7,
        OP_LLD  = 4'd8,
        OP_LST  = 4'd9,
        OP_HLD  = 4'd10,
        OP_HST  = 4'd11,
        OP_L2H  = 4'd12,
        OP_H2L  = 4'd13,
        OP_SGN  = 4'd14,
        OP_NOP  = 4'd15
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_LOAD = 2'd2
    } vstate_e;

    function automatic logic op_is_load(vop_e op);
        return (op == OP_ALD) || (op == OP_ULD) || (op == OP_SLD) ||
               (op == OP_LLD) || (op == OP_HLD);
    endfunction

    function automatic logic op_is_store(vop_e op);
        return (op == OP_AST) || (op == OP_UST) || (op == OP_SST) ||
               (op == OP_LST) || (op == OP_HST);
    endfunction

    function automatic logic op_is_align(vop_e op);
        return (op == OP_ALD) || (op == OP_AST);
    endfunction

    function automatic logic op_wr_reg(vop_e op);
        return (op == OP_VMOV) || (op == OP_SMOV) || (op == OP_L2H) ||
               (op == OP_H2L);
    endfunction

endpackage

// File: rtl/vmov_regfile.sv
module vmov_regfile #(
    parameter int NREG  = 8,
    parameter int VEC_W = 128,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [VEC_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [VEC_W-1:0] rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [VEC_W-1:0] rdata_b
);

    logic [VEC_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (we && (waddr == IDX_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/vmov_lanes.sv
module vmov_lanes
    import vmov_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int VEC_W  = 4 * LANE_W,
    parameter int STRB_W = VEC_W / 8
) (
    input  vop_e              op,
    input  logic [VEC_W-1:0]  src_v,
    input  logic [VEC_W-1:0]  dst_v,
    input  logic [VEC_W-1:0]  rdata,
    output logic [VEC_W-1:0]  res_v,
    output logic [VEC_W-1:0]  wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic [3:0]        sign4
);

    localparam int HALF   = VEC_W / 2;
    localparam int HALF_B = HALF / 8;
    localparam int LANE_B = LANE_W / 8;

    // one sign bit per lane, lane i to bit i
    for (genvar l = 0; l < 4; l++) begin : g_sign
        assign sign4[l] = src_v[l*LANE_W + LANE_W - 1];
    end

    always_comb begin
        res_v = dst_v;
        wdata = '0;
        wstrb = '0;
        unique case (op)
            OP_ALD, OP_ULD: res_v = rdata;
            OP_AST, OP_UST: begin
                wdata = src_v;
                wstrb = '1;
            end
            OP_VMOV: res_v = src_v;
            OP_SLD:  res_v = {{(VEC_W-LANE_W){1'b0}}, rdata[LANE_W-1:0]};
            OP_SST: begin
                wdata = {{(VEC_W-LANE_W){1'b0}}, src_v[LANE_W-1:0]};
                wstrb = {{(STRB_W-LANE_B){1'b0}}, {LANE_B{1'b1}}};
            end
            OP_SMOV: res_v = {dst_v[VEC_W-1:LANE_W], src_v[LANE_W-1:0]};
            OP_LLD:  res_v = {dst_v[VEC_W-1:HALF], rdata[HALF-1:0]};
            OP_LST: begin
                wdata = {{HALF{1'b0}}, src_v[HALF-1:0]};
                wstrb = {{(STRB_W-HALF_B){1'b0}}, {HALF_B{1'b1}}};
            end
            OP_HLD:  res_v = {rdata[HALF-1:0], dst_v[HALF-1:0]};
            OP_HST: begin
                wdata = {{HALF{1'b0}}, src_v[VEC_W-1:HALF]};
                wstrb = {{(STRB_W-HALF_B){1'b0}}, {HALF_B{1'b1}}};
            end
            OP_L2H:  res_v = {src_v[HALF-1:0], dst_v[HALF-1:0]};
            OP_H2L:  res_v = {dst_v[VEC_W-1:HALF], src_v[VEC_W-1:HALF]};
            default: res_v = dst_v;
        endcase
    end

endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
    import vmov_pkg::*;
#(
    parameter  int LANE_W = 32,
    parameter  int NREG   = 8,
    parameter  int ADDR_W = 32,
    parameter  int MASK_W = 32,
    localparam int VEC_W  = 4 * LANE_W,
    localparam int STRB_W = VEC_W / 8,
    localparam int IDX_W  = $clog2(NREG),
    localparam int ALIGN_B = $clog2(STRB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [IDX_W-1:0]  op_dst,
    input  logic [IDX_W-1:0]  op_src,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              op_ready,
    output logic              done,
    output logic              fault,
    output logic [MASK_W-1:0] mask_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VEC_W-1:0]  mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb,
    input  logic [VEC_W-1:0]  mem_rdata
);

    vstate_e           state_q, state_d;
    vop_e              op_q;
    logic [IDX_W-1:0]  dst_q, src_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fault_q, done_q;
    logic [3:0]        mask_q;

    logic              accept, misalign, mem_op, complete, rf_we, mask_we;
    logic [VEC_W-1:0]  src_v, dst_v, res_v, lane_wdata;
    logic [STRB_W-1:0] lane_wstrb;
    logic [3:0]        sign4;

    assign accept   = op_valid && (state_q == ST_IDLE);
    assign misalign = op_is_align(op_q) && (addr_q[ALIGN_B-1:0] != '0);
    assign mem_op   = op_is_load(op_q) || op_is_store(op_q);

    vmov_regfile #(.NREG(NREG), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (dst_q),
        .wdata   (res_v),
        .raddr_a (src_q),
        .rdata_a (src_v),
        .raddr_b (dst_q),
        .rdata_b (dst_v)
    );

    vmov_lanes #(.LANE_W(LANE_W), .VEC_W(VEC_W), .STRB_W(STRB_W)) u_lanes (
        .op    (op_q),
        .src_v (src_v),
        .dst_v (dst_v),
        .rdata (mem_rdata),
        .res_v (res_v),
        .wdata (lane_wdata),
        .wstrb (lane_wstrb),
        .sign4 (sign4)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = (op_is_load(op_q) && !misalign) ? ST_LOAD : ST_IDLE;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the current state
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        rf_we    = 1'b0;
        mask_we  = 1'b0;
        complete = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXEC: begin
                mem_req  = mem_op && !misalign;
                mem_we   = op_is_store(op_q) && !misalign;
                rf_we    = op_wr_reg(op_q);
                mask_we  = (op_q == OP_SGN);
                complete = !(op_is_load(op_q) && !misalign);
            end
            ST_LOAD: begin
                rf_we    = 1'b1;
                complete = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = lane_wdata;
    assign mem_wstrb = mem_we ? lane_wstrb : '0;

    // operation capture and completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            dst_q   <= '0;
            src_q   <= '0;
            addr_q  <= '0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
            mask_q  <= '0;
        end else begin
            done_q <= complete;
            if (accept) begin
                op_q    <= vop_e'(op_code);
                dst_q   <= op_dst;
                src_q   <= op_src;
                addr_q  <= op_addr;
                fault_q <= 1'b0;
            end else if ((state_q == ST_EXEC) && misalign) begin
                fault_q <= 1'b1;
            end
            if (mask_we) mask_q <= sign4;
        end
    end

    assign op_ready = (state_q == ST_IDLE);
    assign done     = done_q;
    assign fault    = fault_q;
    assign mask_out = {{(MASK_W-4){1'b0}}, mask_q};

endmodule

// File: rtl/vmov_unit_chk.sv
module vmov_unit_chk #(
    parameter int STRB_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              done,
    input logic              fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic [STRB_W-1:0] mem_wstrb
);

    localparam logic [STRB_W-1:0] STRB_ALL  = '1;
    localparam logic [STRB_W-1:0] STRB_HALF = STRB_W'((1 << (STRB_W / 2)) - 1);
    localparam logic [STRB_W-1:0] STRB_LANE = STRB_W'((1 << (STRB_W / 4)) - 1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R10

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> op_ready); // R11

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !(op_valid && op_ready)) |=> fault); // R2

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !fault); // R2

    AST_FAULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> done); // R2

    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !$past(mem_req)); // R2

    AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wstrb == STRB_ALL) ||
                                 (mem_wstrb == STRB_HALF) ||
                                 (mem_wstrb == STRB_LANE))); // R4

endmodule

bind vmov_unit vmov_unit_chk #(.STRB_W(STRB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .done      (done),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wstrb (mem_wstrb)
);

// File: tb/vmov_unit_tb_top.sv
module vmov_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [2:0]   op_dst = '0;
    logic [2:0]   op_src = '0;
    logic [31:0]  op_addr = '0;
    logic         op_ready, done, fault;
    logic [31:0]  mask_out;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [15:0]  mem_wstrb;
    logic [127:0] mem_rdata = '0;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [7:0]   mem [256];
    logic [7:0]   shm [256];
    logic [127:0] sreg [8];
    logic [3:0]   smask = '0;

    always #5 clk = ~clk;

    vmov_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .op_src(op_src), .op_addr(op_addr), .op_ready(op_ready),
        .done(done), .fault(fault), .mask_out(mask_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata)
    );

    // byte-addressed memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) begin
            for (int i = 0; i < 16; i++) begin
                mem_rdata[i*8 +: 8] <= mem[8'(mem_addr[7:0] + 8'(i))];
                if (mem_we && mem_wstrb[i])
                    mem[8'(mem_addr[7:0] + 8'(i))] <= mem_wdata[i*8 +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 4:    return "R1";
            2, 3:       return "R3";
            5, 6, 7:    return "R4";
            8, 9:       return "R5";
            10, 11:     return "R6";
            12:         return "R7";
            13:         return "R8";
            14:         return "R9";
            default:    return "R10";
        endcase
    endfunction

    function automatic logic [127:0] srd(input logic [31:0] a);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = shm[8'(a[7:0] + 8'(i))];
        return v;
    endfunction

    task automatic swr(input logic [31:0] a, input logic [127:0] v, input int nb);
        for (int i = 0; i < nb; i++) shm[8'(a[7:0] + 8'(i))] = v[i*8 +: 8];
    endtask

    // shadow model built from the requirements
    task automatic model(input int op, input int d, input int s, input logic [31:0] a,
                         output bit xf, output int xlat);
        logic [127:0] m;
        logic [127:0] sv;
        logic [127:0] dv;
        m  = srd(a);
        sv = sreg[s];
        dv = sreg[d];
        xf = 1'b0;
        xlat = 2;
        if ((op == 0 || op == 1) && a[3:0] != 4'd0) begin
            xf = 1'b1;
            return;
        end
        case (op)
            0, 2:  begin sreg[d] = m; xlat = 3; end
            1, 3:  swr(a, sv, 16);
            4:     sreg[d] = sv;
            5:     begin sreg[d] = {96'd0, m[31:0]}; xlat = 3; end
            6:     swr(a, sv, 4);
            7:     sreg[d] = {dv[127:32], sv[31:0]};
            8:     begin sreg[d] = {dv[127:64], m[63:0]}; xlat = 3; end
            9:     swr(a, sv, 8);
            10:    begin sreg[d] = {m[63:0], dv[63:0]}; xlat = 3; end
            11:    swr(a, {64'd0, sv[127:64]}, 8);
            12:    sreg[d] = {sv[63:0], dv[63:0]};
            13:    sreg[d] = {dv[127:64], sv[127:64]};
            14:    smask = {sv[127], sv[95], sv[63], sv[31]};
            default: ;
        endcase
    endtask

    task automatic run_op(input int op, input int d, input int s, input logic [31:0] a,
                          input string tag);
        bit xf;
        int xlat;
        int n;
        int bad;
        int first;
        model(op, d, s, a, xf, xlat);
        op_valid = 1'b1;
        op_code  = 4'(op);
        op_dst   = 3'(d);
        op_src   = 3'(s);
        op_addr  = a;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == xlat, "R10", $sformatf("latency op%0d", op), 128'(n), 128'(xlat));
        chk(fault == xf, xf ? "R2" : tag, $sformatf("fault op%0d a=%0h", op, a),
            128'(fault), 128'(xf));
        chk(mask_out == {28'd0, smask}, (op == 14) ? "R9" : tag, "mask_out",
            128'(mask_out), 128'({28'd0, smask}));
        bad = 0;
        first = 0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== shm[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        chk(bad == 0, tag, $sformatf("memory byte %0d op%0d", first, op),
            128'(mem[first]), 128'(shm[first]));
    endtask

    // back-to-back full store of a register into scratch space (R11)
    task automatic dump(input int r, input string tag);
        run_op(3, 0, r, 32'h0000_00E0, {tag, "/R11"});
    endtask

    initial begin
        int addrs[13] = '{0, 1, 2, 3, 4, 7, 8, 12, 16, 33, 64, 100, 144};
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'((i * 73 + 19) % 256);
            shm[i] = mem[i];
        end
        for (int i = 0; i < 8; i++) sreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready && !done && !fault && !mem_req, "R12", "idle outputs after reset",
            {124'd0, op_ready, done, fault, mem_req}, 128'h8);
        chk(mask_out == 32'd0, "R12", "mask after reset", 128'(mask_out), 128'd0);
        for (int r = 0; r < 8; r++) dump(r, "R12");

        // fill registers
        for (int r = 0; r < 8; r++) run_op(2, r, 0, 32'(r * 16 + 5), "R3");

        // fault holds until next accept
        run_op(0, 1, 0, 32'h0000_0024, "R2");
        repeat (4) @(negedge clk);
        chk(fault == 1'b1, "R2", "fault held while idle", 128'(fault), 128'd1);
        run_op(15, 0, 0, 32'd0, "R10");
        chk(fault == 1'b0, "R2", "fault cleared by next op", 128'(fault), 128'd0);

        // sweep over codes, addresses and register pairs
        for (int op = 0; op < 16; op++)
            for (int ai = 0; ai < 13; ai++)
                for (int d = 0; d < 8; d++) begin
                    run_op(op, d, (d + 3) % 8, 32'(addrs[ai]), tag_of(op));
                    dump(d, tag_of(op));
                end

        // same register as source and destination
        run_op(12, 5, 5, 32'd0, "R7");
        dump(5, "R7");
        run_op(13, 6, 6, 32'd0, "R8");
        dump(6, "R8");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule